// File: doc/BRIEF.md
# Inline Counter-Mode Read Decryptor

This block sits on the read path between an accelerator's memory master and external DRAM. It handles one 64-byte line per read: the upstream address is forwarded unchanged to memory as an 8-beat, 8-byte-per-beat burst. In the same cycles, the block builds four 128-bit counter values from the line address and a nonce register, and runs them through an iterative AES-256 engine. The ciphertext beats that come back are XORed with the matching keystream half and written straight to the accelerator's private scratchpad port. Plaintext never goes back toward shared memory.

The keystream work begins when the address is accepted, not when data arrives. With a typical DRAM latency, all four keystream blocks are ready before the first beat lands, so the line streams through with no added stall. If memory answers early, the block holds the read channel ready signal low until the needed keystream block exists. Only one line is in flight at a time. A key and a nonce are loaded through a small write-only register port.

Top module: `aesctr_rd_decrypt`

## Requirements
- R1: `sArReady` is high only when no line is in progress. After the upstream address handshake it stays low until the eighth beat has been delivered, and it is high again in the following cycle. Each accepted upstream address produces exactly one downstream request. That request carries `mArAddr` equal to the accepted address, `mArLen`=7 and `mArSize`=3, and holds valid and address steady until `mArReady`.
- R2: For a line at byte address A, keystream block i (i=0..3) is AES-256 under the loaded key of the counter (nonce + ((A>>6)<<2 | i)) mod 2^128. Beat k carries `mRData` XOR keystream block k/2: bits [127:64] for even k and bits [63:0] for odd k.
- R3: Writes with `cfgWe` high load 64-bit words. `cfgAddr` 0 to 3 load key bits [255:192], [191:128], [127:64] and [63:0]. `cfgAddr` 4 and 5 load nonce bits [127:64] and [63:0]. `cfgAddr` 6 and 7 change nothing. Bits 255:248 of the key and bits 127:120 of a block are the first AES byte.
- R4: No beat is accepted or delivered before its keystream block is complete. If memory offers data at once, the first beat is not accepted within 14 cycles of the address handshake.
- R5: Keystream generation starts right after the address handshake, whatever the data timing. If the first beat is offered 70 or more cycles after the handshake, all eight beats are accepted back to back without a stall.
- R6: A beat whose `mRResp` bit 1 is set is delivered with `spData` zero and `spResp` equal to `mRResp`. It still counts toward the eight beats of the line. A beat whose `mRResp` bit 1 is clear is delivered with its decrypted value.
- R7: `spWe` is high only in a cycle with a read data handshake. `spAddr` is then the line base address plus 8·k for beat k.
- R8: After reset, `sArReady` is 1 and `mArValid`, `mRReady` and `spWe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration word select |
| cfgData | input | 64 | Configuration write data |
| sArValid | input | 1 | Upstream read address valid |
| sArReady | output | 1 | Upstream read address ready |
| sArAddr | input | ADDR_W | Upstream line byte address |
| mArValid | output | 1 | Memory read address valid |
| mArReady | input | 1 | Memory read address ready |
| mArAddr | output | ADDR_W | Memory read address |
| mArLen | output | 8 | Burst length minus one |
| mArSize | output | 3 | Log2 of bytes per beat |
| mRValid | input | 1 | Memory read data valid |
| mRReady | output | 1 | Memory read data ready |
| mRData | input | 64 | Ciphertext beat |
| mRResp | input | 2 | Memory read response |
| mRLast | input | 1 | Last beat marker from memory |
| spWe | output | 1 | Scratchpad write enable |
| spAddr | output | ADDR_W | Scratchpad write byte address |
| spData | output | 64 | Plaintext beat |
| spResp | output | 2 | Response passed with the beat |

## Verification
The bench builds the block with ADDR_W=34, so line addresses run above bit 31. The counter sum then spans more than one 32-bit word, and one line uses a nonce whose low word is near all-ones to force carries through the 128-bit addition. The data width, line size and round count stay at their defaults, which gives the 8-beat, four-block sequence. A line at address zero under the standard AES-256 test key and plaintext-as-nonce ties the keystream to a published vector. Latencies from zero to ninety cycles reach both the stalled path and the fully hidden path.

// File: rtl/aesctr_pkg.sv
package aesctr_pkg;
  localparam int DATA_W        = 64;
  localparam int LINE_BYTES    = 64;
  localparam int BLK_W         = 128;
  localparam int KEY_W         = 256;
  localparam int NROUNDS       = 14;
  localparam int BEATS         = LINE_BYTES * 8 / DATA_W;
  localparam int BLOCKS        = LINE_BYTES * 8 / BLK_W;
  localparam int BEATS_PER_BLK = BEATS / BLOCKS;
  localparam int OFS_W         = $clog2(LINE_BYTES);
  localparam int BEAT_W        = $clog2(BEATS);
  localparam int BIDX_W        = $clog2(BLOCKS);
  localparam int CNT_W         = BIDX_W + 1;
  localparam int RND_W         = $clog2(NROUNDS + 2);

  typedef struct packed {
    logic              capture;
    logic              launch;
    logic [BIDX_W-1:0] launchIdx;
    logic              store;
    logic [BIDX_W-1:0] storeIdx;
    logic              beatFire;
    logic [BEAT_W-1:0] beatIdx;
  } ctrlStrobe_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] r, base, inv;
    r = 8'h01;
    base = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gfMul(r, base);
      base = gfMul(base, base);
    end
    inv = r;
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subWord(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [127:0] roundFn(input logic [127:0] s,
                                           input logic [127:0] rk,
                                           input logic lastRnd);
    logic [7:0] b [16];
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] o;
    for (int j = 0; j < 16; j++) b[j] = sbox(s[127-8*j -: 8]);
    for (int j = 0; j < 16; j++) t[j] = b[(j + 4*(j%4)) % 16];
    for (int c = 0; c < 4; c++) begin
      a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
      if (lastRnd) o[127-32*c -: 32] = {a0, a1, a2, a3};
      else o[127-32*c -: 32] = {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                                a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                                a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                                xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    end
    return o ^ rk;
  endfunction

  // round key n from keys n-2 (kA) and n-1 (kB)
  function automatic logic [127:0] nextKey(input logic [127:0] kA,
                                           input logic [127:0] kB,
                                           input logic [RND_W-1:0] n);
    logic [31:0] tmp, w0, w1, w2, w3;
    logic [7:0] rc;
    rc = 8'h01 << ((n >> 1) - 1);
    if (!n[0]) tmp = subWord({kB[23:0], kB[31:24]}) ^ {rc, 24'h0};
    else tmp = subWord(kB[31:0]);
    w0 = kA[127:96] ^ tmp;
    w1 = kA[95:64] ^ w0;
    w2 = kA[63:32] ^ w1;
    w3 = kA[31:0] ^ w2;
    return {w0, w1, w2, w3};
  endfunction
endpackage

// File: rtl/aesctr_core.sv
module aesctr_core
  import aesctr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [KEY_W-1:0] key,
  input  logic             startIn,
  input  logic [BLK_W-1:0] blkIn,
  output logic             running,
  output logic             doneP,
  output logic [BLK_W-1:0] blkOut
);
  logic [BLK_W-1:0] stateQ, kA, kB;
  logic [RND_W-1:0] rnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      doneP   <= 1'b0;
      rnd     <= '0;
      stateQ  <= '0;
      kA      <= '0;
      kB      <= '0;
    end else begin
      doneP <= 1'b0;
      if (startIn) begin
        stateQ  <= blkIn ^ key[KEY_W-1 -: BLK_W];
        kA      <= key[KEY_W-1 -: BLK_W];
        kB      <= key[BLK_W-1:0];
        rnd     <= RND_W'(1);
        running <= 1'b1;
      end else if (running) begin
        stateQ <= roundFn(stateQ, kB, rnd == RND_W'(NROUNDS));
        kA     <= kB;
        kB     <= nextKey(kA, kB, rnd + RND_W'(1));
        rnd    <= rnd + RND_W'(1);
        if (rnd == RND_W'(NROUNDS)) begin
          running <= 1'b0;
          doneP   <= 1'b1;
        end
      end
    end
  end

  assign blkOut = stateQ;

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |-> !running);
  // R2
  done_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> $past(startIn, 15));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);
endmodule

// File: rtl/aesctr_ctrl.sv
module aesctr_ctrl
  import aesctr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sArValid,
  output logic        sArReady,
  output logic        mArValid,
  input  logic        mArReady,
  input  logic        mRValid,
  input  logic        mRLast,
  output logic        mRReady,
  output logic        spWe,
  input  logic        coreRun,
  input  logic        coreDone,
  output ctrlStrobe_t st
);
  typedef enum logic {IDLE, BUSY} fsm_t;
  localparam logic [CNT_W-1:0] NBLK = CNT_W'(BLOCKS);

  fsm_t              fsm;
  logic [CNT_W-1:0]  genCnt, doneCnt;
  logic [BEAT_W-1:0] beatCnt;
  logic [BIDX_W-1:0] beatBlk;
  logic arFire, beatFire, lastBeat, ksReady, launch;

  assign sArReady = (fsm == IDLE) && !coreRun;
  assign arFire   = sArValid && sArReady;
  assign beatBlk  = beatCnt[BEAT_W-1 -: BIDX_W];
  assign ksReady  = doneCnt > {1'b0, beatBlk};
  assign mRReady  = (fsm == BUSY) && ksReady;
  assign beatFire = mRValid && mRReady;
  assign spWe     = beatFire;
  assign lastBeat = beatFire && (beatCnt == BEAT_W'(BEATS - 1) || mRLast);
  assign launch   = (fsm == BUSY) && !coreRun && (genCnt < NBLK);

  always_comb begin
    st.capture   = arFire;
    st.launch    = launch;
    st.launchIdx = genCnt[BIDX_W-1:0];
    st.store     = coreDone;
    st.storeIdx  = doneCnt[BIDX_W-1:0];
    st.beatFire  = beatFire;
    st.beatIdx   = beatCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm      <= IDLE;
      mArValid <= 1'b0;
      genCnt   <= '0;
      doneCnt  <= '0;
      beatCnt  <= '0;
    end else if (arFire) begin
      fsm      <= BUSY;
      mArValid <= 1'b1;
      genCnt   <= '0;
      doneCnt  <= '0;
      beatCnt  <= '0;
    end else begin
      if (mArValid && mArReady) mArValid <= 1'b0;
      if (launch)   genCnt  <= genCnt + CNT_W'(1);
      if (coreDone) doneCnt <= doneCnt + CNT_W'(1);
      if (beatFire) beatCnt <= beatCnt + BEAT_W'(1);
      if (lastBeat) fsm <= IDLE;
    end
  end

  // R1
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mArValid && !mArReady |=> mArValid);
  // R1
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatFire && beatCnt == BEAT_W'(BEATS - 1)) |=> (fsm == IDLE));
endmodule

// File: rtl/aesctr_dpath.sv
module aesctr_dpath
  import aesctr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] sArAddr,
  input  ctrlStrobe_t       st,
  input  logic [DATA_W-1:0] mRData,
  input  logic [1:0]        mRResp,
  output logic [ADDR_W-1:0] mArAddr,
  output logic [ADDR_W-1:0] spAddr,
  output logic [DATA_W-1:0] spData,
  output logic [1:0]        spResp,
  output logic              coreRun,
  output logic              coreDone
);
  localparam int LINE_W   = ADDR_W - OFS_W;
  localparam int KEY_WRDS = KEY_W / DATA_W;
  localparam int NON_WRDS = BLK_W / DATA_W;

  logic [KEY_W-1:0]  keyReg;
  logic [BLK_W-1:0]  nonceReg;
  logic [ADDR_W-1:0] addrReg;
  logic [BLK_W-1:0]  ksBuf [BLOCKS];
  logic [BLOCKS-1:0] ksValid;
  logic [BLK_W-1:0]  ctrIn, coreOut, ksBlk;
  logic [DATA_W-1:0] ksHalf;
  logic              beatOff;

  // configuration words: key first, then nonce, high word first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg   <= '0;
      nonceReg <= '0;
    end else if (cfgWe) begin
      for (int i = 0; i < KEY_WRDS; i++)
        if (cfgAddr == 3'(i)) keyReg[KEY_W-1-DATA_W*i -: DATA_W] <= cfgData;
      for (int i = 0; i < NON_WRDS; i++)
        if (cfgAddr == 3'(KEY_WRDS + i)) nonceReg[BLK_W-1-DATA_W*i -: DATA_W] <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      ksValid <= '0;
    end else begin
      if (st.capture) begin
        addrReg <= sArAddr;
        ksValid <= '0;
      end else if (st.store) begin
        ksValid[st.storeIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.store) ksBuf[st.storeIdx] <= coreOut;
  end

  assign ctrIn = nonceReg + BLK_W'({addrReg[ADDR_W-1:OFS_W], st.launchIdx});

  aesctr_core i_core (
    .clk     (clk),
    .rstN    (rstN),
    .key     (keyReg),
    .startIn (st.launch),
    .blkIn   (ctrIn),
    .running (coreRun),
    .doneP   (coreDone),
    .blkOut  (coreOut)
  );

  assign beatOff = st.beatIdx[0];
  assign ksBlk   = ksBuf[st.beatIdx[BEAT_W-1 -: BIDX_W]];
  assign ksHalf  = ksBlk[BLK_W-1 - DATA_W*int'(beatOff) -: DATA_W];

  assign mArAddr = addrReg;
  assign spAddr  = {addrReg[ADDR_W-1:OFS_W], st.beatIdx, (OFS_W-BEAT_W)'(0)};
  assign spResp  = mRResp;
  assign spData  = mRResp[1] ? '0 : (mRData ^ ksHalf);

  // R4
  ks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.beatFire |-> ksValid[st.beatIdx[BEAT_W-1 -: BIDX_W]]);
  // R4
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.launch |-> !ksValid[st.launchIdx]);
endmodule

// File: rtl/aesctr_rd_decrypt.sv
module aesctr_rd_decrypt
  import aesctr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [63:0]       cfgData,
  input  logic              sArValid,
  output logic              sArReady,
  input  logic [ADDR_W-1:0] sArAddr,
  output logic              mArValid,
  input  logic              mArReady,
  output logic [ADDR_W-1:0] mArAddr,
  output logic [7:0]        mArLen,
  output logic [2:0]        mArSize,
  input  logic              mRValid,
  output logic              mRReady,
  input  logic [63:0]       mRData,
  input  logic [1:0]        mRResp,
  input  logic              mRLast,
  output logic              spWe,
  output logic [ADDR_W-1:0] spAddr,
  output logic [63:0]       spData,
  output logic [1:0]        spResp
);
  ctrlStrobe_t st;
  logic coreRun, coreDone;

  assign mArLen  = 8'(BEATS - 1);
  assign mArSize = 3'($clog2(DATA_W / 8));

  aesctr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sArValid (sArValid),
    .sArReady (sArReady),
    .mArValid (mArValid),
    .mArReady (mArReady),
    .mRValid  (mRValid),
    .mRLast   (mRLast),
    .mRReady  (mRReady),
    .spWe     (spWe),
    .coreRun  (coreRun),
    .coreDone (coreDone),
    .st       (st)
  );

  aesctr_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .sArAddr  (sArAddr),
    .st       (st),
    .mRData   (mRData),
    .mRResp   (mRResp),
    .mArAddr  (mArAddr),
    .spAddr   (spAddr),
    .spData   (spData),
    .spResp   (spResp),
    .coreRun  (coreRun),
    .coreDone (coreDone)
  );
endmodule

// File: tb/test_aesctr_rd_decrypt.sv
module test_aesctr_rd_decrypt;
  localparam int AW = 34;

  logic clk = 0, rstN = 0;
  logic cfgWe = 0;
  logic [2:0] cfgAddr = '0;
  logic [63:0] cfgData = '0;
  logic sArValid = 0, mArReady = 0, mRValid = 0, mRLast = 0;
  logic [AW-1:0] sArAddr = '0;
  logic [63:0] mRData = '0;
  logic [1:0] mRResp = '0;
  logic sArReady, mArValid, mRReady, spWe;
  logic [AW-1:0] mArAddr, spAddr;
  logic [7:0] mArLen;
  logic [2:0] mArSize;
  logic [63:0] spData;
  logic [1:0] spResp;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  logic [7:0] sb [256];
  logic [255:0] key;
  logic [127:0] nonce;

  always #2.5 clk = ~clk;

  aesctr_rd_decrypt #(.ADDR_W(AW)) i_aesctr_rd_decrypt (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .sArValid(sArValid), .sArReady(sArReady), .sArAddr(sArAddr),
    .mArValid(mArValid), .mArReady(mArReady), .mArAddr(mArAddr),
    .mArLen(mArLen), .mArSize(mArSize),
    .mRValid(mRValid), .mRReady(mRReady), .mRData(mRData), .mRResp(mRResp),
    .mRLast(mRLast), .spWe(spWe), .spAddr(spAddr), .spData(spData), .spResp(spResp));

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0, x = a, y = b;
    while (y != 0) begin
      if (y[0]) acc ^= x;
      x = m2(x);
      y = y >> 1;
    end
    return acc;
  endfunction

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [127:0] refEnc(input logic [255:0] k, input logic [127:0] p);
    logic [31:0] w [60];
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [31:0] tmp;
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    for (int i = 8; i < 60; i++) begin
      tmp = w[i-1];
      if (i % 8 == 0) begin
        tmp = sw({tmp[23:0], tmp[31:24]}) ^ {rc, 24'h0};
        rc = m2(rc);
      end else if (i % 8 == 4) tmp = sw(tmp);
      w[i] = w[i-8] ^ tmp;
    end
    for (int j = 0; j < 16; j++) s[j] = p[127-8*j -: 8] ^ w[j/4][31-8*(j%4) -: 8];
    for (int r = 1; r <= 14; r++) begin
      for (int j = 0; j < 16; j++) t[j] = sb[s[(j + 4*(j%4)) % 16]];
      for (int c = 0; c < 4; c++) begin
        if (r == 14) for (int q = 0; q < 4; q++) s[4*c+q] = t[4*c+q];
        else for (int q = 0; q < 4; q++)
          s[4*c+q] = gm(t[4*c+q], 2) ^ gm(t[4*c+(q+1)%4], 3) ^
                     t[4*c+(q+2)%4] ^ t[4*c+(q+3)%4];
      end
      for (int j = 0; j < 16; j++) s[j] ^= w[4*r + j/4][31-8*(j%4) -: 8];
    end
    for (int j = 0; j < 16; j++) res[127-8*j -: 8] = s[j];
    return res;
  endfunction

  task automatic cfgWrite(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    cfgWe = 1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic loadKeys();
    for (int i = 0; i < 4; i++) cfgWrite(3'(i), key[255-64*i -: 64]);
    cfgWrite(3'd4, nonce[127:64]);
    cfgWrite(3'd5, nonce[63:0]);
  endtask

  // one line; lat and arDelay are counted in cycles after the address handshake
  task automatic doLine(input logic [AW-1:0] addr, input int lat, input int arDelay,
                        input logic [7:0] errMask, input bit zeroCt,
                        input logic [127:0] fipsExp, input bit useFips);
    logic [127:0] ks [4];
    logic [63:0] ct [8];
    logic [63:0] expD, ksH;
    int n = 0, beat = 0, firstAcc = -1, presAt = -1;
    bit arDone = 0, arNext = 0, arChecked = 0, stalled = 0, busyRdy = 0;
    bit extraAr = 0, weBad = 0;
    for (int i = 0; i < 4; i++)
      ks[i] = refEnc(key, nonce + 128'({addr[AW-1:6], 2'(i)}));
    for (int k = 0; k < 8; k++) ct[k] = zeroCt ? 64'h0 : {$urandom, $urandom};
    @(negedge clk);
    sArValid = 1; sArAddr = addr;
    #1 chk(sArReady == 1, "R1 idle ready", 128'(sArReady), 128'd1);
    @(negedge clk);
    sArValid = 0; sArAddr = AW'({$urandom, $urandom});
    while (beat < 8 && n < 400) begin
      mArReady = (n >= arDelay);
      mRValid = arDone && (n >= lat);
      mRData = ct[beat];
      mRResp = errMask[beat] ? 2'b10 : 2'b00;
      mRLast = (beat == 7);
      #1;
      if (sArReady) busyRdy = 1;
      if (mArValid && arDone) extraAr = 1;
      if (mArValid && !arDone) begin
        if (!arChecked) begin
          chk(mArAddr == addr, "R1 mArAddr", 128'(mArAddr), 128'(addr));
          chk(mArLen == 8'd7 && mArSize == 3'd3, "R1 len/size",
              128'({mArLen, mArSize}), 128'({8'd7, 3'd3}));
          arChecked = 1;
        end else if (mArAddr != addr) extraAr = 1;
        if (mArReady) arNext = 1;
      end
      if (mRValid) begin
        if (presAt < 0) presAt = n;
        if (mRReady) begin
          if (firstAcc < 0) firstAcc = n;
          if (n != presAt) stalled = 1;
          ksH = beat[0] ? ks[beat/2][63:0] : ks[beat/2][127:64];
          expD = errMask[beat] ? 64'h0 : (ct[beat] ^ ksH);
          chk(spData == expD, errMask[beat] ? "R6 error beat data" : "R2 beat data",
              128'(spData), 128'(expD));
          if (useFips && beat < 2)
            chk(spData == (beat == 0 ? fipsExp[127:64] : fipsExp[63:0]),
                "R2 known vector", 128'(spData),
                128'(beat == 0 ? fipsExp[127:64] : fipsExp[63:0]));
          chk(spWe == 1 && spAddr == addr + AW'(8*beat) && spResp == mRResp, "R7 write port",
              128'({spWe, spAddr, spResp}), 128'({1'b1, addr + AW'(8*beat), mRResp}));
          beat++;
          presAt = -1;
        end else if (spWe) weBad = 1;
      end else if (spWe) weBad = 1;
      @(posedge clk);
      arDone = arDone | arNext;
      @(negedge clk);
      n++;
    end
    mRValid = 0; mArReady = 0; mRLast = 0;
    #1;
    chk(beat == 8, "R1 line completes", 128'(beat), 128'd8);
    chk(!busyRdy && !extraAr, "R1 single outstanding", 128'({busyRdy, extraAr}), 128'd0);
    chk(sArReady == 1, "R1 ready after last beat", 128'(sArReady), 128'd1);
    chk(!weBad, "R7 no write without handshake", 128'(weBad), 128'd0);
    if (lat < 14)
      chk(firstAcc >= 14, "R4 early data held off", 128'(firstAcc), 128'd14);
    if (lat >= 70)
      chk(!stalled && firstAcc == lat, "R5 latency hidden", 128'({stalled, 16'(firstAcc)}),
          128'({1'b0, 16'(lat)}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    endRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      sb[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
              {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R8 reset state
    chk(sArReady == 1 && mArValid == 0 && mRReady == 0 && spWe == 0, "R8 reset outputs",
        128'({sArReady, mArValid, mRReady, spWe}), 128'(4'b1000));

    // R2 known vector: nonce equal to the standard plaintext, line 0, zero ciphertext
    key = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    nonce = 128'h00112233445566778899aabbccddeeff;
    loadKeys();
    doLine('0, 70, 0, 8'h00, 1, 128'h8ea2b7ca516745bfeafc49904b496089, 1);

    // R4 data at once, R3 writes to unused words change nothing
    cfgWrite(3'd6, 64'hdeadbeefdeadbeef);
    cfgWrite(3'd7, 64'h0123456789abcdef);
    doLine(34'h2_dead_be40, 0, 0, 8'h00, 0, '0, 0);

    // R3 new key and a nonce whose low word forces carries
    key = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    nonce = {$urandom, $urandom, 64'hffff_ffff_ffff_fffd};
    loadKeys();
    doLine(34'h3_ffff_ffc0, 5, 3, 8'h00, 0, '0, 0);
    // R6 error beats mixed in
    doLine(34'h1_0000_0040, 80, 1, 8'b1000_0101, 0, '0, 0);

    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a = {AW'({$urandom, $urandom})} & ~AW'(63);
      logic [7:0] em = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      doLine(a, $urandom_range(0, 90), $urandom_range(0, 3), em, 0, '0, 0);
    end
    endRun();
  end
endmodule